// File: doc/BRIEF.md
# Set/Clear Mailbox Register Bank

This block holds a bank of 32-bit mailboxes, grouped as a fixed number of mailboxes per processor core (four cores with four mailboxes each by default, sixteen in all). A sender posts bits into a mailbox by writing to its set address. Every 1 in the written word is ORed into the mailbox and every 0 leaves its bit unchanged. The receiving core acknowledges bits by writing to the mailbox's clear address. Every 1 in that word clears the matching mailbox bit. The clear address also serves as the read address for the mailbox.

Each mailbox drives one pending line, which is high whenever the mailbox holds any nonzero value. The interrupt router uses these lines as mailbox sources. The bank offers several independent write ports so that more than one master can post or acknowledge in the same cycle. It also has one registered read port. All accesses are 32 bits wide and word aligned, and the decoded space ends at byte offset 0x100.

Top module: `mbox_bank`

## Requirements
- R1: While reset is asserted, and directly after it, every mailbox is zero, every pending line is low and rd_data is zero.
- R2: A write of data D to byte offset 0x80 + 4*k sets mailbox k to (old | D). No other mailbox changes.
- R3: A write of data D to byte offset 0xC0 + 4*k sets mailbox k to (old & ~D). No other mailbox changes.
- R4: A read with rd_en high at offset 0xC0 + 4*k loads mailbox k into rd_data on that clock edge, so the value appears one cycle after the request. The value is the content from before any write taken at the same edge.
- R5: A read anywhere in the set window (0x80 to 0xBF), or below 0x80, returns zero.
- R6: Bit k of pending, where k = 4*core + slot, is high exactly when mailbox k is nonzero. It follows a write on the clock edge that takes the write.
- R7: When several write ports target the same mailbox in one cycle, all set data is ORed together and then all clear data is applied. A bit that is both set and cleared in that cycle ends up 0.
- R8: Writes below offset 0x80 have no effect. Address bits [1:0] are ignored for both writes and reads.
- R9: rd_data holds its value in every cycle in which rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | NUM_WR | Write strobe, one bit per write port |
| wr_addr | input | NUM_WR*ADDR_W | Byte offsets, port p in bits [p*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_WR*DATA_W | Write data, port p in bits [p*DATA_W +: DATA_W] |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Registered read data |
| pending | output | NUM_CORES*BOX_PER_CORE | Per-mailbox nonzero flags |

## Verification
The assertions assume that rst_n is driven to a known level on every edge. They also assume that wr_en, rd_en and both address buses are never X or Z when they are sampled. The pending properties rely on the internal combined set and clear masks, so they hold for any mix of port traffic. The bench changes every input only on the falling clock edge. It holds reset for several cycles before the first access, and it keeps all strobes low while reset is active.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } mb_win_e;

  // Word-aligned offset: the low two address bits never select anything.
  function automatic int unsigned word_off(input int unsigned raw);
    return raw & ~32'd3;
  endfunction

  // Which window a word offset falls in, given the window bases and box count.
  function automatic mb_win_e classify(input int unsigned off,
                                       input int unsigned set_base,
                                       input int unsigned clr_base,
                                       input int unsigned nbox);
    if (off >= set_base && off < set_base + 4 * nbox) return WIN_SET;
    if (off >= clr_base && off < clr_base + 4 * nbox) return WIN_CLR;
    return WIN_NONE;
  endfunction

  // Mailbox index inside a window.
  function automatic int unsigned slot_of(input int unsigned off,
                                          input int unsigned base);
    return (off - base) >> 2;
  endfunction

endpackage

// File: rtl/mbox_wr_decode.sv
module mbox_wr_decode #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          NUM_BOX  = 16,
  parameter int unsigned SET_BASE = 32'h80,
  parameter int unsigned CLR_BASE = 32'hC0
) (
  input  logic                      en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         data,
  output logic [NUM_BOX*DATA_W-1:0] set_mask,
  output logic [NUM_BOX*DATA_W-1:0] clr_mask
);
  import mbox_pkg::*;

  int unsigned off;
  int unsigned idx;
  mb_win_e     win;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    off      = word_off(32'(addr));
    win      = classify(off, SET_BASE, CLR_BASE, NUM_BOX);
    idx      = 0;
    if (en) begin
      case (win)
        WIN_SET: begin
          idx = slot_of(off, SET_BASE);
          set_mask[idx*DATA_W +: DATA_W] = data;
        end
        WIN_CLR: begin
          idx = slot_of(off, CLR_BASE);
          clr_mask[idx*DATA_W +: DATA_W] = data;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int DATA_W  = 32,
  parameter int NUM_BOX = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_BOX*DATA_W-1:0] set_any,
  input  logic [NUM_BOX*DATA_W-1:0] clr_any,
  output logic [NUM_BOX*DATA_W-1:0] box_flat,
  output logic [NUM_BOX-1:0]        pending
);

  // Sets merge first and clears are applied last, so a clear wins on overlap.
  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] cur,
                                              input logic [DATA_W-1:0] s,
                                              input logic [DATA_W-1:0] c);
    return (cur | s) & ~c;
  endfunction

  for (genvar g = 0; g < NUM_BOX; g++) begin : g_box
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= merge(q, set_any[g*DATA_W +: DATA_W], clr_any[g*DATA_W +: DATA_W]);
    end

    assign box_flat[g*DATA_W +: DATA_W] = q;
    assign pending[g]                   = |q;
  end

endmodule

// File: rtl/mbox_rd_port.sv
module mbox_rd_port #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          NUM_BOX  = 16,
  parameter int unsigned SET_BASE = 32'h80,
  parameter int unsigned CLR_BASE = 32'hC0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [NUM_BOX*DATA_W-1:0] box_flat,
  output logic [DATA_W-1:0]         rd_data
);
  import mbox_pkg::*;

  int unsigned       off;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    off     = word_off(32'(rd_addr));
    if (classify(off, SET_BASE, CLR_BASE, NUM_BOX) == WIN_CLR)
      rd_next = box_flat[slot_of(off, CLR_BASE)*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

endmodule

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int          NUM_CORES    = 4,
  parameter int          BOX_PER_CORE = 4,
  parameter int          DATA_W       = 32,
  parameter int          ADDR_W       = 8,
  parameter int          NUM_WR       = 2,
  parameter int unsigned SET_BASE     = 32'h80,
  parameter int unsigned CLR_BASE     = 32'hC0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_WR-1:0]                   wr_en,
  input  logic [NUM_WR*ADDR_W-1:0]            wr_addr,
  input  logic [NUM_WR*DATA_W-1:0]            wr_data,
  input  logic                                rd_en,
  input  logic [ADDR_W-1:0]                   rd_addr,
  output logic [DATA_W-1:0]                   rd_data,
  output logic [NUM_CORES*BOX_PER_CORE-1:0]   pending
);
  localparam int NUM_BOX = NUM_CORES * BOX_PER_CORE;
  localparam int FLAT_W  = NUM_BOX * DATA_W;

  logic [FLAT_W-1:0] port_set [NUM_WR];
  logic [FLAT_W-1:0] port_clr [NUM_WR];
  // Combined masks across all write ports, visible to the checker.
  logic [FLAT_W-1:0] set_any;
  logic [FLAT_W-1:0] clr_any;
  logic [FLAT_W-1:0] box_flat;

  for (genvar p = 0; p < NUM_WR; p++) begin : g_port
    mbox_wr_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BOX(NUM_BOX),
      .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_dec (
      .en       (wr_en[p]),
      .addr     (wr_addr[p*ADDR_W +: ADDR_W]),
      .data     (wr_data[p*DATA_W +: DATA_W]),
      .set_mask (port_set[p]),
      .clr_mask (port_clr[p])
    );
  end

  always_comb begin
    set_any = '0;
    clr_any = '0;
    for (int p = 0; p < NUM_WR; p++) begin
      set_any = set_any | port_set[p];
      clr_any = clr_any | port_clr[p];
    end
  end

  mbox_store #(.DATA_W(DATA_W), .NUM_BOX(NUM_BOX)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_any  (set_any),
    .clr_any  (clr_any),
    .box_flat (box_flat),
    .pending  (pending)
  );

  mbox_rd_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BOX(NUM_BOX),
    .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .box_flat (box_flat),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          NUM_BOX  = 16,
  parameter int          NUM_WR   = 2,
  parameter int unsigned SET_BASE = 32'h80,
  parameter int unsigned CLR_BASE = 32'hC0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_WR-1:0]         wr_en,
  input logic [NUM_WR*ADDR_W-1:0]  wr_addr,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         rd_addr,
  input logic [DATA_W-1:0]         rd_data,
  input logic [NUM_BOX-1:0]        pending,
  input logic [NUM_BOX*DATA_W-1:0] set_any,
  input logic [NUM_BOX*DATA_W-1:0] clr_any
);
  localparam int unsigned LO_EDGE = (SET_BASE < CLR_BASE) ? SET_BASE : CLR_BASE;

  logic any_hit;
  logic rd_in_set;

  always_comb begin
    any_hit = 1'b0;
    for (int p = 0; p < NUM_WR; p++)
      if (wr_en[p] && 32'(wr_addr[p*ADDR_W +: ADDR_W]) >= LO_EDGE) any_hit = 1'b1;
    rd_in_set = (32'(rd_addr) >= SET_BASE) && (32'(rd_addr) < SET_BASE + 4 * NUM_BOX);
  end

  // R1: reset forces every pending line low.
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |-> (pending == '0 && rd_data == '0));

  // R5: set-window reads come back zero.
  a_r5_set_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_in_set) |=> (rd_data == '0));

  // R9: idle read port keeps its data.
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R8: no write into the mailbox windows leaves every pending line unchanged.
  a_r8_no_hit_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |=> $stable(pending));

  for (genvar k = 0; k < NUM_BOX; k++) begin : g_k
    // R2: surviving set bits raise pending.
    a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_any[k*DATA_W +: DATA_W] & ~clr_any[k*DATA_W +: DATA_W]) != '0) |=> pending[k]);
    // R3: clearing with all ones drops pending.
    a_r3_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (&clr_any[k*DATA_W +: DATA_W]) |=> !pending[k]);
    // R6: pending only rises through a set.
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending[k] && set_any[k*DATA_W +: DATA_W] == '0) |=> !pending[k]);
    // R6: pending only falls through a clear.
    a_r6_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (pending[k] && clr_any[k*DATA_W +: DATA_W] == '0) |=> pending[k]);
  end

endmodule

bind mbox_bank mbox_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BOX(NUM_BOX), .NUM_WR(NUM_WR),
  .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pending(pending),
  .set_any(set_any), .clr_any(clr_any)
);

// File: tb/mbox_bank_test.sv
`timescale 1ns/1ps
module mbox_bank_test;
  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  wr_en = '0;
  logic [15:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] pending;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m [NB];

  always #5 clk = ~clk;

  mbox_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pending(pending)
  );

  function automatic logic [7:0] sa(int k); return 8'(128 + 4 * k); endfunction
  function automatic logic [7:0] ca(int k); return 8'(192 + 4 * k); endfunction
  function automatic logic [31:0] pat(int k, int r);
    return (32'h9E3779B9 * 32'(k + 1 + 16 * r)) | (32'h1 << k);
  endfunction
  function automatic logic [15:0] exp_pend();
    logic [15:0] v;
    for (int k = 0; k < NB; k++) v[k] = (m[k] != 0);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr1(int p, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en[p] = 1'b1; wr_addr[p*8 +: 8] = a; wr_data[p*32 +: 32] = d;
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic wr2(logic [7:0] a0, logic [31:0] d0, logic [7:0] a1, logic [31:0] d1);
    @(negedge clk);
    wr_en = 2'b11; wr_addr = {a1, a0}; wr_data = {d1, d0};
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic sweep(string tag);
    logic [31:0] d;
    for (int k = 0; k < NB; k++) begin
      rd(ca(k), d);
      chk(tag, d, m[k]);
    end
    chk({tag, " pending"}, 32'(pending), 32'(exp_pend()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    for (int k = 0; k < NB; k++) m[k] = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset pending", 32'(pending), 32'h0);
    chk("R1 reset rd_data", rd_data, 32'h0);
    rst_n = 1'b1;
    sweep("R1 R4 post-reset read");

    // R2 R6: set each box in turn on alternating ports, watching pending order
    for (int k = 0; k < NB; k++) begin
      wr1(k % 2, sa(k), pat(k, 0));
      m[k] |= pat(k, 0);
      chk("R6 pending order", 32'(pending), 32'(exp_pend()));
    end
    sweep("R2 R4 first set");
    for (int k = 0; k < NB; k++) begin
      wr1((k + 1) % 2, sa(k), pat(k, 1));
      m[k] |= pat(k, 1);
    end
    sweep("R2 accumulate");

    // R3: partial clears
    for (int k = 0; k < NB; k++) begin
      wr1(k % 2, ca(k), pat(k, 2));
      m[k] &= ~pat(k, 2);
    end
    sweep("R3 partial clear");

    // R5: set window and low region read as zero
    for (int k = 0; k < NB; k++) begin
      rd(sa(k), d);
      chk("R5 set window read", d, 32'h0);
    end
    for (int a = 0; a < 128; a += 4) begin
      rd(8'(a), d);
      chk("R5 low region read", d, 32'h0);
    end

    // R8: writes below the windows do nothing
    for (int a = 0; a < 128; a += 4) wr2(8'(a), 32'hFFFF_FFFF, 8'(a + 1), 32'hFFFF_FFFF);
    sweep("R8 low writes ignored");

    // R8: address low bits ignored
    wr1(0, 8'(sa(2) + 3), 32'h0000_0100);
    m[2] |= 32'h0000_0100;
    rd(8'(ca(2) + 2), d);
    chk("R8 low addr bits", d, m[2]);

    // R7: two ports set same box
    wr1(0, ca(5), 32'hFFFF_FFFF); m[5] = '0;
    wr2(sa(5), 32'hFF00_FF00, sa(5), 32'h0F0F_0F0F);
    m[5] = 32'hFF0F_FF0F;
    rd(ca(5), d);
    chk("R7 dual set", d, m[5]);
    // R7: set and clear same bits, clear wins
    wr1(1, ca(6), 32'hFFFF_FFFF); m[6] = '0;
    wr2(sa(6), 32'h0000_FFFF, ca(6), 32'h0000_00FF);
    m[6] = 32'h0000_FF00;
    rd(ca(6), d);
    chk("R7 clear wins", d, m[6]);
    wr2(ca(6), 32'h0000_FF00, sa(6), 32'h0000_FF00);
    m[6] = '0;
    chk("R7 R6 clear wins pending", 32'(pending[6]), 32'h0);

    // R4: read in same cycle as write returns old content
    @(negedge clk);
    rd_en = 1'b1; rd_addr = ca(3);
    wr_en[0] = 1'b1; wr_addr[7:0] = sa(3); wr_data[31:0] = 32'hA5A5_0000;
    @(negedge clk);
    rd_en = 1'b0; wr_en = '0;
    chk("R4 read before write", rd_data, m[3]);
    m[3] |= 32'hA5A5_0000;

    // R9: rd_data holds while rd_en low
    held = rd_data;
    wr1(1, sa(3), 32'h0000_5A5A);
    m[3] |= 32'h0000_5A5A;
    repeat (3) @(negedge clk);
    chk("R9 rd hold", rd_data, held);

    // R3 R6: clear everything, pending falls box by box
    for (int k = 0; k < NB; k++) begin
      wr1(k % 2, ca(k), 32'hFFFF_FFFF);
      m[k] = '0;
      chk("R3 R6 full clear pending", 32'(pending), 32'(exp_pend()));
    end
    sweep("R3 all clear");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule